// File: doc/BRIEF.md
# Load Effective Address Unit

This block forms the effective address of a fixed-point load from the fields an instruction decoder has already pulled out. It takes the addressing form, an update flag, the base and target register indices, the base and index register values and the raw 16-bit displacement field. It returns the effective address. For update forms it also returns a writeback of that address into the base register. It raises a flag when the operand combination is not a legal encoding.

Memory access, the register file and formatting of the loaded data belong to other blocks. The address path itself is combinational. A parameter selects whether the results pass through one output register stage, which is the default, or leave the block directly.

A base index of zero selects a literal zero base only for non-update forms. Each displacement form scales and sign-extends its field differently. The low field bits that a form does not use are ignored.

Top module: `lea_unit`

## Requirements
- R1: For a non-update form (update_i=0) with ra_idx_i=0, the base is zero. With any other index the base is ra_val_i.
- R2: For an update form (update_i=1), the base is always ra_val_i, including when ra_idx_i=0.
- R3: Form code 0 (D form) adds disp_i, sign-extended from 16 bits, to the base.
- R4: Form code 1 (DS form) adds disp_i[15:2] followed by two zero bits, sign-extended from bit 15. disp_i[1:0] has no effect on the address.
- R5: Form code 2 (DQ form) adds disp_i[15:4] followed by four zero bits, sign-extended from bit 15. disp_i[3:0] has no effect on the address.
- R6: Form code 3 (X form) adds rb_val_i to the base, and disp_i has no effect.
- R7: The addition wraps modulo 2^64 and reports no carry.
- R8: A valid update form asserts wb_en_o, and wb_val_o equals ea_o.
- R9: An update form with ra_idx_i=0 or ra_idx_i equal to rt_idx_i raises invalid_o.
- R10: Form code 2 raises invalid_o when rt_idx_i is odd or equal to ra_idx_i, including when both are 0.
- R11: wb_en_o is never asserted together with invalid_o. A non-update form never asserts wb_en_o.
- R12: With OUT_REG=1, all outputs appear one clock after the inputs. While rst_n is low all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| form_i | input | 2 | Addressing form: 0 D, 1 DS, 2 DQ, 3 X |
| update_i | input | 1 | Update form: write the address back to the base register |
| ra_idx_i | input | 5 | Base register index |
| rt_idx_i | input | 5 | Target register index |
| ra_val_i | input | 64 | Base register contents |
| rb_val_i | input | 64 | Index register contents |
| disp_i | input | 16 | Raw displacement field |
| ea_o | output | 64 | Effective address |
| wb_en_o | output | 1 | Base register writeback enable |
| wb_val_o | output | 64 | Base register writeback value |
| invalid_o | output | 1 | Invalid-form flag |

## Verification
Directed cases cover these patterns:
- A zero base index with and without update, which separates the literal-zero rule from the register-base rule.
- Negative displacements in each form, which show whether sign extension is taken from the correct bit.
- Nonzero low field bits in the DS and DQ forms, which expose any scaling that keeps those bits.
- Base values near 2^64, which show that the sum wraps.
- Odd and equal target indices with the quadword form, and equal or zero indices with update, which separate the two invalid rules and show whether writeback is suppressed.

Random operands with biased indices then mix all forms and flags, and each result is compared with a model computed in the bench.

// File: rtl/lea_pkg.sv
package lea_pkg;

    localparam int XLEN   = 64;
    localparam int IDX_W  = 5;
    localparam int DISP_W = 16;

    typedef enum logic [1:0] {
        FORM_D  = 2'd0,
        FORM_DS = 2'd1,
        FORM_DQ = 2'd2,
        FORM_X  = 2'd3
    } form_e;

    typedef struct packed {
        logic [XLEN-1:0] ea;
        logic            wb_en;
        logic [XLEN-1:0] wb_val;
        logic            invalid;
    } lea_out_t;

endpackage

// File: rtl/lea_disp_scale.sv
module lea_disp_scale #(
    parameter int XLEN   = 64,
    parameter int DISP_W = 16
) (
    input  logic [1:0]        form_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [XLEN-1:0]   offs_o
);
    import lea_pkg::*;

    localparam int DS_LOW = 2;
    localparam int DQ_LOW = 4;

    logic [DISP_W-1:0] field;

    always_comb begin
        unique case (form_e'(form_i))
            FORM_DS: field = {disp_i[DISP_W-1:DS_LOW], {DS_LOW{1'b0}}};
            FORM_DQ: field = {disp_i[DISP_W-1:DQ_LOW], {DQ_LOW{1'b0}}};
            default: field = disp_i;
        endcase
        offs_o = {{(XLEN-DISP_W){field[DISP_W-1]}}, field};
    end

endmodule

// File: rtl/lea_base_sel.sv
module lea_base_sel #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input  logic             update_i,
    input  logic [IDX_W-1:0] ra_idx_i,
    input  logic [XLEN-1:0]  ra_val_i,
    output logic [XLEN-1:0]  base_o
);
    logic zero_base;

    always_comb begin
        zero_base = !update_i && (ra_idx_i == '0);
        base_o    = zero_base ? '0 : ra_val_i;
    end

endmodule

// File: rtl/lea_form_check.sv
module lea_form_check #(
    parameter int IDX_W = 5
) (
    input  logic [1:0]       form_i,
    input  logic             update_i,
    input  logic [IDX_W-1:0] ra_idx_i,
    input  logic [IDX_W-1:0] rt_idx_i,
    output logic             invalid_o
);
    import lea_pkg::*;

    logic same_idx;
    logic upd_bad;
    logic quad_bad;

    always_comb begin
        same_idx  = (ra_idx_i == rt_idx_i);
        upd_bad   = update_i && ((ra_idx_i == '0) || same_idx);
        quad_bad  = (form_e'(form_i) == FORM_DQ) && (rt_idx_i[0] || same_idx);
        invalid_o = upd_bad || quad_bad;
    end

endmodule

// File: rtl/lea_unit.sv
module lea_unit #(
    parameter int XLEN    = lea_pkg::XLEN,
    parameter int IDX_W   = lea_pkg::IDX_W,
    parameter int DISP_W  = lea_pkg::DISP_W,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        form_i,
    input  logic              update_i,
    input  logic [IDX_W-1:0]  ra_idx_i,
    input  logic [IDX_W-1:0]  rt_idx_i,
    input  logic [XLEN-1:0]   ra_val_i,
    input  logic [XLEN-1:0]   rb_val_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [XLEN-1:0]   ea_o,
    output logic              wb_en_o,
    output logic [XLEN-1:0]   wb_val_o,
    output logic              invalid_o
);
    import lea_pkg::*;

    typedef struct packed {
        logic [XLEN-1:0] ea;
        logic            wb_en;
        logic [XLEN-1:0] wb_val;
        logic            invalid;
    } res_t;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offs;
    logic            bad;
    res_t            res_d;

    lea_base_sel #(.XLEN(XLEN), .IDX_W(IDX_W)) u_base (
        .update_i (update_i),
        .ra_idx_i (ra_idx_i),
        .ra_val_i (ra_val_i),
        .base_o   (base)
    );

    lea_disp_scale #(.XLEN(XLEN), .DISP_W(DISP_W)) u_disp (
        .form_i (form_i),
        .disp_i (disp_i),
        .offs_o (offs)
    );

    lea_form_check #(.IDX_W(IDX_W)) u_chk_form (
        .form_i    (form_i),
        .update_i  (update_i),
        .ra_idx_i  (ra_idx_i),
        .rt_idx_i  (rt_idx_i),
        .invalid_o (bad)
    );

    always_comb begin
        logic [XLEN-1:0] addend;
        addend        = (form_e'(form_i) == FORM_X) ? rb_val_i : offs;
        res_d.ea      = base + addend;
        res_d.invalid = bad;
        res_d.wb_en   = update_i && !bad;
        res_d.wb_val  = res_d.ea;
    end

    generate
        if (OUT_REG) begin : g_reg
            res_t res_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q <= '0;
                end else begin
                    res_q <= res_d;
                end
            end
            assign ea_o      = res_q.ea;
            assign wb_en_o   = res_q.wb_en;
            assign wb_val_o  = res_q.wb_val;
            assign invalid_o = res_q.invalid;
        end else begin : g_comb
            assign ea_o      = res_d.ea;
            assign wb_en_o   = res_d.wb_en;
            assign wb_val_o  = res_d.wb_val;
            assign invalid_o = res_d.invalid;
        end
    endgenerate

endmodule

// File: rtl/lea_unit_chk.sv
module lea_unit_chk #(
    parameter int XLEN    = 64,
    parameter int IDX_W   = 5,
    parameter int DISP_W  = 16,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        form_i,
    input logic              update_i,
    input logic [IDX_W-1:0]  ra_idx_i,
    input logic [IDX_W-1:0]  rt_idx_i,
    input logic [XLEN-1:0]   ra_val_i,
    input logic [XLEN-1:0]   rb_val_i,
    input logic [DISP_W-1:0] disp_i,
    input logic [XLEN-1:0]   ea_o,
    input logic              wb_en_o,
    input logic [XLEN-1:0]   wb_val_o,
    input logic              invalid_o
);
    generate
        if (OUT_REG) begin : g_seq
            logic past_ok;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) past_ok <= 1'b0;
                else        past_ok <= 1'b1;
            end

            p_upd_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(update_i) &&
                 (($past(ra_idx_i) == '0) || ($past(ra_idx_i) == $past(rt_idx_i))))
                |-> invalid_o);

            p_quad_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && ($past(form_i) == 2'd2) &&
                 ($past(rt_idx_i[0]) || ($past(ra_idx_i) == $past(rt_idx_i))))
                |-> invalid_o);

            p_wb_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
                invalid_o |-> !wb_en_o);

            p_wb_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
                wb_en_o |-> (wb_val_o == ea_o));

            p_wb_needs_update_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && !$past(update_i)) |-> !wb_en_o);

            p_index_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && ($past(form_i) == 2'd3) && $past(update_i))
                |-> (ea_o == $past(ra_val_i) + $past(rb_val_i)));

            p_reset_clear_r12: assert property (@(posedge clk)
                !rst_n |-> (ea_o == '0 && !wb_en_o && !invalid_o));
        end else begin : g_cmb
            always_comb begin
                if (rst_n) begin
                    a_wb_blocked_r11: assert (!(invalid_o && wb_en_o));
                    if (wb_en_o) a_wb_value_r8: assert (wb_val_o == ea_o);
                    if (update_i && (ra_idx_i == '0 || ra_idx_i == rt_idx_i))
                        a_upd_invalid_r9: assert (invalid_o);
                    if (form_i == 2'd3 && update_i && disp_i == disp_i)
                        a_index_sum_r6: assert (ea_o == ra_val_i + rb_val_i);
                end
            end
        end
    endgenerate

endmodule

bind lea_unit lea_unit_chk #(
    .XLEN(XLEN), .IDX_W(IDX_W), .DISP_W(DISP_W), .OUT_REG(OUT_REG)
) u_lea_chk (
    .clk(clk), .rst_n(rst_n), .form_i(form_i), .update_i(update_i),
    .ra_idx_i(ra_idx_i), .rt_idx_i(rt_idx_i), .ra_val_i(ra_val_i),
    .rb_val_i(rb_val_i), .disp_i(disp_i), .ea_o(ea_o), .wb_en_o(wb_en_o),
    .wb_val_o(wb_val_o), .invalid_o(invalid_o)
);

// File: tb/sim_lea_unit.sv
module sim_lea_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  form;
    logic        upd;
    logic [4:0]  ra_idx, rt_idx;
    logic [63:0] ra_val, rb_val;
    logic [15:0] disp;
    logic [63:0] ea, wb_val;
    logic        wb_en, invalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lea_unit u0 (
        .clk(clk), .rst_n(rst_n), .form_i(form), .update_i(upd),
        .ra_idx_i(ra_idx), .rt_idx_i(rt_idx), .ra_val_i(ra_val),
        .rb_val_i(rb_val), .disp_i(disp), .ea_o(ea), .wb_en_o(wb_en),
        .wb_val_o(wb_val), .invalid_o(invalid)
    );

    function automatic logic [63:0] m_ea(logic [1:0] f, logic u, logic [4:0] ri,
                                         logic [63:0] rv, logic [63:0] bv, logic [15:0] d);
        logic [63:0] b, o;
        b = (!u && ri == 5'd0) ? 64'd0 : rv;
        case (f)
            2'd0: o = 64'($signed(d));
            2'd1: o = 64'($signed({d[15:2], 2'b00}));
            2'd2: o = 64'($signed({d[15:4], 4'b0000}));
            default: o = bv;
        endcase
        return b + o;
    endfunction

    function automatic logic m_bad(logic [1:0] f, logic u, logic [4:0] ri, logic [4:0] ti);
        logic bad;
        bad = u && (ri == 5'd0 || ri == ti);
        if (f == 2'd2 && (ti[0] || ti == ri)) bad = 1'b1;
        return bad;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(string req, logic [1:0] f, logic u, logic [4:0] ri, logic [4:0] ti,
                       logic [63:0] rv, logic [63:0] bv, logic [15:0] d);
        logic [63:0] e;
        logic b;
        @(negedge clk);
        form = f; upd = u; ra_idx = ri; rt_idx = ti; ra_val = rv; rb_val = bv; disp = d;
        e = m_ea(f, u, ri, rv, bv, d);
        b = m_bad(f, u, ri, ti);
        @(negedge clk);
        chk({req, " ea"}, ea, e);
        chk({req, " invalid"}, 64'(invalid), 64'(b));
        chk({req, " wb_en"}, 64'(wb_en), 64'(u && !b));
        if (u && !b) chk({req, " wb_val"}, wb_val, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1ea5));
        form = 2'd0; upd = 1'b1; ra_idx = 5'd3; rt_idx = 5'd4;
        ra_val = 64'hFFFF; rb_val = 64'h1; disp = 16'h10;
        repeat (3) @(negedge clk);
        // R12: reset clears outputs
        chk("R12 reset ea", ea, 64'd0);
        chk("R12 reset wb_en", 64'(wb_en), 64'd0);
        chk("R12 reset invalid", 64'(invalid), 64'd0);
        rst_n = 1'b1;

        run("R1 zero base",        2'd0, 1'b0, 5'd0, 5'd2, 64'h1234_5678, 64'd0, 16'h0100);
        run("R1 reg base",         2'd0, 1'b0, 5'd7, 5'd2, 64'h1234_5678, 64'd0, 16'h0100);
        run("R2 update idx0 base", 2'd0, 1'b1, 5'd0, 5'd2, 64'h4000, 64'd0, 16'h0008);
        run("R3 D negative",       2'd0, 1'b0, 5'd5, 5'd6, 64'h1000, 64'd0, 16'hFFF0);
        run("R4 DS low bits",      2'd1, 1'b0, 5'd5, 5'd6, 64'h1000, 64'd0, 16'h0013);
        run("R4 DS negative",      2'd1, 1'b1, 5'd5, 5'd6, 64'h1000, 64'd0, 16'h8003);
        run("R5 DQ low bits",      2'd2, 1'b0, 5'd5, 5'd6, 64'h2000, 64'd0, 16'h012F);
        run("R5 DQ negative",      2'd2, 1'b0, 5'd3, 5'd8, 64'h2000, 64'd0, 16'hFFFF);
        run("R6 X ignores disp",   2'd3, 1'b0, 5'd9, 5'd1, 64'h100, 64'h55, 16'h7777);
        run("R6 X zero base",      2'd3, 1'b0, 5'd0, 5'd1, 64'h100, 64'h55, 16'h0001);
        run("R7 wrap",             2'd3, 1'b1, 5'd9, 5'd1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 16'd0);
        run("R7 wrap D",           2'd0, 1'b0, 5'd9, 5'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'h0002);
        run("R8 update wb",        2'd3, 1'b1, 5'd4, 5'd5, 64'h800, 64'h8, 16'd0);
        run("R9 upd ra0",          2'd0, 1'b1, 5'd0, 5'd5, 64'h800, 64'd0, 16'h4);
        run("R9 upd ra eq rt",     2'd3, 1'b1, 5'd6, 5'd6, 64'h800, 64'h4, 16'd0);
        run("R10 DQ odd rt",       2'd2, 1'b0, 5'd4, 5'd7, 64'h800, 64'd0, 16'h10);
        run("R10 DQ rt eq ra",     2'd2, 1'b0, 5'd6, 5'd6, 64'h800, 64'd0, 16'h10);
        run("R10 DQ both zero",    2'd2, 1'b0, 5'd0, 5'd0, 64'h800, 64'd0, 16'h10);
        run("R10 DQ legal",        2'd2, 1'b0, 5'd3, 5'd6, 64'h800, 64'd0, 16'h10);
        run("R11 non-update eq",   2'd0, 1'b0, 5'd6, 5'd6, 64'h800, 64'd0, 16'h10);

        for (int i = 0; i < NRAND; i++) begin
            logic [4:0] ri, ti;
            ri = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
            ti = ($urandom % 4 == 0) ? ri : 5'($urandom);
            run("R1-mix random R11", 2'($urandom), 1'($urandom), ri, ti,
                {$urandom, $urandom}, {$urandom, $urandom}, 16'($urandom));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule